// File: doc/BRIEF.md
# Setup-Mode Configuration Port Router

This block decodes a byte-wide I/O bus on a channel-based system board. It keeps three control registers: a system control port, a setup-enable port and an adapter-setup port. From the state of those registers it sends each access to the eight option-select ports at 0x100 through 0x107 to one of three targets. The targets are the planar register bank, a small built-in video option register that also imitates two identification bytes, and the adapter slot selected by the adapter-setup register.

The bus uses one-cycle read and write strobes. Each read strobe returns its data in a register one clock later. The planar bank and the adapter logic sit outside the block. The block gives them a shared port offset and write data, and it gives each of them its own read and write strobes. Each strobe is asserted only when the route selects that target. The block also drives a slot index, a one-cycle CPU reset pulse and an alternate A20 gate.

Top module: `setup_port_router`

## Requirements
- R1: After reset the setup-enable register (0x94) reads 0xFF, and the system control (0x92) and adapter-setup (0x96) registers hold 0x00. Reads of 0x92 and 0x94 return the last value written.
- R2: While setup-enable bit 7 is 0, every read or write of 0x100–0x107 goes to the planar strobes. No adapter strobe is asserted, and the read returns the planar data.
- R3: While setup-enable bit 7 is 1 and bit 5 is 0 (video setup), reads of 0x100, 0x101 and 0x102 return 0xFD, 0xEF and the stored video option byte. A write to 0x102 updates that byte and reaches neither external target.
- R4: In video setup, reads of 0x103–0x107 return 0xFF and assert no strobe.
- R5: While setup-enable bits 7 and 5 are both 1, an access to 0x100–0x107 reaches the adapter strobes only when adapter-setup bit 3 is 1. Otherwise a read returns 0xFF and no strobe is asserted.
- R6: With setup-enable bit 7 at 1, writes to 0x103–0x107 reach the adapter whenever adapter-setup bit 3 is 1, whatever the value of bit 5. In video setup, writes to 0x100 and 0x101 are dropped.
- R7: A read of 0x96 returns the adapter-setup register OR 0x70. The slot index output equals bits 2:0 of that register.
- R8: A write to 0x92 with data bit 0 at 1, while the stored bit 0 is 0, raises the CPU reset output for exactly the one cycle after the write. Any other write to 0x92 gives no pulse.
- R9: The alternate A20 output follows bit 1 of the system control register from the cycle after the write.
- R10: A read of any address outside 0x92, 0x94, 0x96 and 0x100–0x107 returns 0xFF.
- R11: Read data appears on the cycle after the read strobe and holds until the next read. When read and write strobes come together, only the write takes place.
- R12: At most one external strobe is active in any cycle. The option port offset and the write data are presented with each external strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Registered read data |
| opt_offset | output | 3 | Offset of the option port being accessed |
| opt_wdata | output | 8 | Write data to the external targets |
| planar_rd | output | 1 | Planar bank read strobe |
| planar_wr | output | 1 | Planar bank write strobe |
| planar_rdata | input | 8 | Planar bank read data |
| adapter_rd | output | 1 | Adapter read strobe |
| adapter_wr | output | 1 | Adapter write strobe |
| adapter_rdata | input | 8 | Adapter read data |
| slot_index | output | 3 | Selected adapter slot |
| cpu_reset | output | 1 | One-cycle CPU reset pulse |
| a20_alt | output | 1 | Alternate A20 enable |

## Verification
The hardest case to reach is the video setup state, where reads and writes to the same option port go to different places. A write to 0x104 must still reach the adapter, but a read of 0x104 must return 0xFF. To reach this state the stimulus programs 0x96 with the enable bit set and then writes 0x94 with bit 7 set and bit 5 clear. It then issues reads and writes to the same ports and checks the strobes one by one. The reset pulse edge case is reached by writing 0x92 twice with bit 0 set: only the first write may produce a pulse.

// File: rtl/setup_router_pkg.sv
package setup_router_pkg;
  localparam int unsigned SETUP_IO_BIT  = 7;
  localparam int unsigned SETUP_VID_BIT = 5;
  localparam int unsigned ADP_EN_BIT    = 3;
  localparam int unsigned SYS_RST_BIT   = 0;
  localparam int unsigned SYS_A20_BIT   = 1;

  typedef enum logic [1:0] {
    RT_NONE,
    RT_PLANAR,
    RT_VIDEO,
    RT_ADAPTER
  } route_e;
endpackage

// File: rtl/spr_ctrl_regs.sv
module spr_ctrl_regs #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SLOT_W     = 3,
  parameter logic [7:0]  SETUP_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sys,
  input  logic              wr_setup,
  input  logic              wr_adp,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sys_q,
  output logic [DATA_W-1:0] setup_q,
  output logic [DATA_W-1:0] adp_q,
  output logic [SLOT_W-1:0] slot_index,
  output logic              cpu_reset,
  output logic              a20_alt
);
  import setup_router_pkg::*;

  logic rst_edge;
  assign rst_edge = wr_sys && wdata[SYS_RST_BIT] && !sys_q[SYS_RST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q     <= '0;
      setup_q   <= SETUP_INIT[DATA_W-1:0];
      adp_q     <= '0;
      cpu_reset <= 1'b0;
    end else begin
      cpu_reset <= rst_edge;
      if (wr_sys)   sys_q   <= wdata;
      if (wr_setup) setup_q <= wdata;
      if (wr_adp)   adp_q   <= wdata;
    end
  end

  assign slot_index = adp_q[SLOT_W-1:0];
  assign a20_alt    = sys_q[SYS_A20_BIT];

  // R8: pulse lasts a single cycle
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
    cpu_reset |=> !cpu_reset);

  // R8: a pulse needs a prior write raising bit 0
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    (wr_sys && !wdata[SYS_RST_BIT]) |=> !cpu_reset);

  // R9: A20 follows the written bit
  a_r9_a20_follow: assert property (@(posedge clk) disable iff (rst)
    wr_sys |=> (a20_alt == $past(wdata[SYS_A20_BIT])));
endmodule

// File: rtl/spr_route.sv
module spr_route #(
  parameter int unsigned OFF_W     = 3,
  parameter int unsigned VID_PORTS = 3,
  parameter int unsigned VID_WPORT = 2
) (
  input  logic                            opt_hit,
  input  logic                            is_wr,
  input  logic [OFF_W-1:0]                off,
  input  logic                            setup_io,
  input  logic                            setup_vid,
  input  logic                            adp_en,
  output setup_router_pkg::route_e        route
);
  import setup_router_pkg::*;

  logic low_port;
  assign low_port = (32'(off) < VID_PORTS);

  always_comb begin
    route = RT_NONE;
    if (!opt_hit) begin
      route = RT_NONE;
    end else if (!setup_io) begin
      route = RT_PLANAR;
    end else if (!setup_vid) begin
      if (is_wr) begin
        if (32'(off) == VID_WPORT)   route = RT_VIDEO;
        else if (!low_port && adp_en) route = RT_ADAPTER;
        else                         route = RT_NONE;
      end else begin
        route = low_port ? RT_VIDEO : RT_NONE;
      end
    end else if (adp_en) begin
      route = RT_ADAPTER;
    end
  end
endmodule

// File: rtl/spr_video_opt.sv
module spr_video_opt #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFF_W  = 3,
  parameter logic [7:0]  ID_LO  = 8'hFD,
  parameter logic [7:0]  ID_HI  = 8'hEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] vid_q;

  always_ff @(posedge clk) begin
    if (rst)        vid_q <= '0;
    else if (wr_en) vid_q <= wdata;
  end

  always_comb begin
    case (off)
      OFF_W'(0): rdata = ID_LO[DATA_W-1:0];
      OFF_W'(1): rdata = ID_HI[DATA_W-1:0];
      default:   rdata = vid_q;
    endcase
  end

  // R3: byte only changes on a routed write
  a_r3_vid_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(vid_q));
endmodule

// File: rtl/setup_port_router.sv
module setup_port_router #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned OPT_PORTS = 8,
  parameter logic [15:0] SYS_ADDR  = 16'h0092,
  parameter logic [15:0] SET_ADDR  = 16'h0094,
  parameter logic [15:0] ADP_ADDR  = 16'h0096,
  parameter logic [15:0] OPT_BASE  = 16'h0100
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [$clog2(OPT_PORTS)-1:0]  opt_offset,
  output logic [DATA_W-1:0]             opt_wdata,
  output logic                          planar_rd,
  output logic                          planar_wr,
  input  logic [DATA_W-1:0]             planar_rdata,
  output logic                          adapter_rd,
  output logic                          adapter_wr,
  input  logic [DATA_W-1:0]             adapter_rdata,
  output logic [SLOT_W-1:0]             slot_index,
  output logic                          cpu_reset,
  output logic                          a20_alt
);
  import setup_router_pkg::*;

  localparam int unsigned OFF_W = $clog2(OPT_PORTS);
  localparam logic [DATA_W-1:0] ALL_ONES  = '1;
  localparam logic [DATA_W-1:0] ADP_FORCE = DATA_W'(8'h70);

  logic rd_eff, hit_sys, hit_set, hit_adp, opt_hit;
  logic [DATA_W-1:0] sys_q, setup_q, adp_q, vid_rdata, rd_mux;
  route_e route;

  assign rd_eff  = bus_rd && !bus_wr;
  assign hit_sys = (bus_addr == SYS_ADDR[ADDR_W-1:0]);
  assign hit_set = (bus_addr == SET_ADDR[ADDR_W-1:0]);
  assign hit_adp = (bus_addr == ADP_ADDR[ADDR_W-1:0]);
  assign opt_hit = (bus_addr[ADDR_W-1:OFF_W] == OPT_BASE[ADDR_W-1:OFF_W]);
  assign opt_offset = bus_addr[OFF_W-1:0];
  assign opt_wdata  = bus_wdata;

  spr_ctrl_regs #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .wr_sys(bus_wr && hit_sys), .wr_setup(bus_wr && hit_set),
    .wr_adp(bus_wr && hit_adp), .wdata(bus_wdata),
    .sys_q(sys_q), .setup_q(setup_q), .adp_q(adp_q),
    .slot_index(slot_index), .cpu_reset(cpu_reset), .a20_alt(a20_alt)
  );

  spr_route #(.OFF_W(OFF_W)) route_i (
    .opt_hit(opt_hit), .is_wr(bus_wr), .off(opt_offset),
    .setup_io(setup_q[SETUP_IO_BIT]), .setup_vid(setup_q[SETUP_VID_BIT]),
    .adp_en(adp_q[ADP_EN_BIT]), .route(route)
  );

  spr_video_opt #(.DATA_W(DATA_W), .OFF_W(OFF_W)) video_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr && route == RT_VIDEO),
    .wdata(bus_wdata), .off(opt_offset), .rdata(vid_rdata)
  );

  assign planar_rd  = rd_eff && (route == RT_PLANAR);
  assign planar_wr  = bus_wr && (route == RT_PLANAR);
  assign adapter_rd = rd_eff && (route == RT_ADAPTER);
  assign adapter_wr = bus_wr && (route == RT_ADAPTER);

  always_comb begin
    rd_mux = ALL_ONES;
    if (hit_sys)      rd_mux = sys_q;
    else if (hit_set) rd_mux = setup_q;
    else if (hit_adp) rd_mux = adp_q | ADP_FORCE;
    else if (opt_hit) begin
      case (route)
        RT_PLANAR:  rd_mux = planar_rdata;
        RT_VIDEO:   rd_mux = vid_rdata;
        RT_ADAPTER: rd_mux = adapter_rdata;
        default:    rd_mux = ALL_ONES;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_eff) bus_rdata <= rd_mux;
  end

  // R12: never two external strobes together
  a_r12_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({planar_rd, planar_wr, adapter_rd, adapter_wr}));

  // R2: planar wins whenever setup bit 7 is low
  a_r2_planar_first: assert property (@(posedge clk) disable iff (rst)
    (opt_hit && (bus_rd || bus_wr) && !setup_q[SETUP_IO_BIT]) |-> (planar_rd || planar_wr));

  // R5: adapter strobes need the enable bit
  a_r5_adapter_gate: assert property (@(posedge clk) disable iff (rst)
    (adapter_rd || adapter_wr) |-> adp_q[ADP_EN_BIT]);

  // R11: read data holds between reads
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_eff |=> $stable(bus_rdata));

  // R7: slot index follows a write of the adapter port
  a_r7_slot_follow: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_adp) |=> (slot_index == $past(bus_wdata[SLOT_W-1:0])));
endmodule

// File: tb/setup_port_router_tb_top.sv
module setup_port_router_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata, opt_wdata, planar_rdata, adapter_rdata;
  logic [2:0]  opt_offset, slot_index;
  logic        planar_rd, planar_wr, adapter_rd, adapter_wr, cpu_reset, a20_alt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  assign planar_rdata  = {5'b10100, opt_offset};
  assign adapter_rdata = {5'b01010, opt_offset};

  setup_port_router dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .opt_offset(opt_offset), .opt_wdata(opt_wdata),
    .planar_rd(planar_rd), .planar_wr(planar_wr), .planar_rdata(planar_rdata),
    .adapter_rd(adapter_rd), .adapter_wr(adapter_wr), .adapter_rdata(adapter_rdata),
    .slot_index(slot_index), .cpu_reset(cpu_reset), .a20_alt(a20_alt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mask: bit3 planar_rd, bit2 planar_wr, bit1 adapter_rd, bit0 adapter_wr
  task automatic do_op(input string req, input bit wr, input bit rd,
                       input logic [15:0] a, input logic [7:0] d,
                       input logic [7:0] exp, input logic [3:0] mask);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
    #1;
    check({req, " strobes"}, {12'h0, planar_rd, planar_wr, adapter_rd, adapter_wr}, {12'h0, mask});
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (rd && !wr) check({req, " rdata"}, {8'h0, bus_rdata}, {8'h0, exp});
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [3:0]  mask;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'h0094, 8'h00, 8'hFF, 4'h0}, // R1 setup reset value
    '{1'b0, 16'h0092, 8'h00, 8'h00, 4'h0}, // R1 sysctl reset value
    '{1'b0, 16'h0096, 8'h00, 8'h70, 4'h0}, // R7 forced bits
    '{1'b0, 16'h0100, 8'h00, 8'hFF, 4'h0}, // R5 adapter disabled
    '{1'b1, 16'h0096, 8'h0D, 8'h00, 4'h0}, // R7 slot 5, enable
    '{1'b0, 16'h0096, 8'h00, 8'h7D, 4'h0}, // R7 readback
    '{1'b0, 16'h0103, 8'h00, 8'h53, 4'h2}, // R5 adapter read
    '{1'b1, 16'h0104, 8'h33, 8'h00, 4'h1}, // R5 adapter write
    '{1'b1, 16'h0094, 8'h7F, 8'h00, 4'h0}, // R2 planar mode
    '{1'b0, 16'h0105, 8'h00, 8'hA5, 4'h8}, // R2 planar read
    '{1'b1, 16'h0100, 8'h11, 8'h00, 4'h4}, // R2 planar write
    '{1'b0, 16'h0094, 8'h00, 8'h7F, 4'h0}, // R1 readback
    '{1'b1, 16'h0094, 8'hDF, 8'h00, 4'h0}, // R3 video mode
    '{1'b0, 16'h0100, 8'h00, 8'hFD, 4'h0}, // R3 id low
    '{1'b0, 16'h0101, 8'h00, 8'hEF, 4'h0}, // R3 id high
    '{1'b0, 16'h0102, 8'h00, 8'h00, 4'h0}, // R3 byte reset
    '{1'b1, 16'h0102, 8'h5A, 8'h00, 4'h0}, // R3 byte write
    '{1'b0, 16'h0102, 8'h00, 8'h5A, 4'h0}, // R3 byte read
    '{1'b0, 16'h0106, 8'h00, 8'hFF, 4'h0}, // R4 no read target
    '{1'b1, 16'h0106, 8'h77, 8'h00, 4'h1}, // R6 write reaches adapter
    '{1'b1, 16'h0101, 8'h44, 8'h00, 4'h0}, // R6 dropped
    '{1'b0, 16'h0200, 8'h00, 8'hFF, 4'h0}, // R10 unmapped
    '{1'b0, 16'h0091, 8'h00, 8'hFF, 4'h0}, // R10 unmapped neighbour
    '{1'b0, 16'h0102, 8'h00, 8'h5A, 4'h0}  // R3 byte kept after dropped write
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rdata reset", {8'h0, bus_rdata}, 16'h0000);
    check("R9 a20 reset", {15'h0, a20_alt}, 16'h0000);
    check("R8 pulse reset", {15'h0, cpu_reset}, 16'h0000);
    check("R7 slot reset", {13'h0, slot_index}, 16'h0000);

    for (int i = 0; i < NV; i++)
      do_op($sformatf("vec%0d", i), TBL[i].wr, !TBL[i].wr, TBL[i].addr,
            TBL[i].data, TBL[i].exp, TBL[i].mask);

    // R7 slot index output
    check("R7 slot", {13'h0, slot_index}, 16'h0005);

    // R5 enable cleared, full adapter mode
    do_op("R5 disable", 1, 0, 16'h0096, 8'h05, 8'h00, 4'h0);
    do_op("R5 mode", 1, 0, 16'h0094, 8'hFF, 8'h00, 4'h0);
    do_op("R5 gated read", 0, 1, 16'h0107, 8'h00, 8'hFF, 4'h0);
    do_op("R5 gated write", 1, 0, 16'h0107, 8'h99, 8'h00, 4'h0);

    // R12 offset and data presented with a planar write
    do_op("R12 planar mode", 1, 0, 16'h0094, 8'h00, 8'h00, 4'h0);
    @(negedge clk);
    bus_addr = 16'h0106; bus_wdata = 8'hC3; bus_wr = 1'b1;
    #1;
    check("R12 offset", {13'h0, opt_offset}, 16'h0006);
    check("R12 wdata", {8'h0, opt_wdata}, 16'h00C3);
    @(negedge clk); bus_wr = 1'b0;

    // R11 simultaneous read and write: write only, rdata holds
    do_op("R11 prime", 0, 1, 16'h0094, 8'h00, 8'h00, 4'h0);
    do_op("R11 both", 1, 1, 16'h0101, 8'h22, 8'h00, 4'h4);
    check("R11 hold", {8'h0, bus_rdata}, 16'h0000);

    // R8 rising edge pulse, R9 A20
    do_op("R8 raise", 1, 0, 16'h0092, 8'h01, 8'h00, 4'h0);
    check("R8 pulse high", {15'h0, cpu_reset}, 16'h0001);
    check("R9 a20 low", {15'h0, a20_alt}, 16'h0000);
    @(negedge clk);
    check("R8 pulse ends", {15'h0, cpu_reset}, 16'h0000);
    do_op("R8 repeat", 1, 0, 16'h0092, 8'h03, 8'h00, 4'h0);
    check("R8 no second pulse", {15'h0, cpu_reset}, 16'h0000);
    check("R9 a20 high", {15'h0, a20_alt}, 16'h0001);
    do_op("R1 sys readback", 0, 1, 16'h0092, 8'h00, 8'h03, 4'h0);
    do_op("R9 clear", 1, 0, 16'h0092, 8'h00, 8'h00, 4'h0);
    check("R9 a20 cleared", {15'h0, a20_alt}, 16'h0000);
    check("R8 no pulse on clear", {15'h0, cpu_reset}, 16'h0000);
    do_op("R8 raise again", 1, 0, 16'h0092, 8'h01, 8'h00, 4'h0);
    check("R8 second rise pulses", {15'h0, cpu_reset}, 16'h0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule